// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffer and Status Flags

This block receives asynchronous serial frames on a single input line. A single free-running counter, advanced by a 16x oversampling clock enable, paces the whole frame. A falling edge on the line starts the count. The line must still be low at the middle of the start bit before the frame is accepted. After that, every bit is taken at the centre of its bit period. A state machine walks through the frame: start check, data bits, an optional parity bit, and one or two stop bits. At the middle of the final stop bit, the assembled character goes into a one-entry receive buffer and a one-cycle interrupt request is raised.

Host software reads the buffer and the status register through simple strobes. A buffer read frees the buffer. A write to the status register, with any value, clears the error flags. Control inputs switch the serial function and the receiver on and off, and select the frame format. Parity, framing and overrun errors are sticky, and a summary bit reports any of them. When a frame completes while the buffer still holds unread data, the new frame is discarded for good.

The state machine has six states, and each transition is named by the event that causes it:
- IDLE → START on a falling line edge.
- START → DATA when the mid-start sample is low.
- START → IDLE when the mid-start sample is high, which rejects a glitch.
- DATA → DATA after each bit that is not the last.
- DATA → PARITY after the last data bit when parity is on.
- DATA → STOP1 after the last data bit when parity is off.
- PARITY → STOP1 after the parity sample.
- STOP1 → IDLE on frame completion with one stop bit.
- STOP1 → STOP2 when two stop bits are selected.
- STOP2 → IDLE on frame completion.
- Any state → IDLE while the receiver is inactive.

Top module: `uart_rx_core`

## Requirements
- R1: While the serial function and the receiver are both enabled, a falling edge on `rxd` starts a frame. The frame is abandoned with no further effect if `rxd` is high at the middle of the start bit, eight oversampling ticks after the edge.
- R2: Data bits arrive least significant bit first, one every 16 ticks. `ctl_len8`=1 selects 8 data bits and `ctl_len8`=0 selects 7; in 7-bit mode, `rx_data[7]` reads 0.
- R3: At the mid-point of the final stop bit, the frame completes. One cycle later, `status[1]` (buffer full) is 1 unless the frame overran, and `rx_irq` is high for exactly one cycle.
- R4: A `rd_buf` pulse clears `status[1]` on the next cycle.
- R5: `status[4]` (parity error) is set when parity is enabled (`ctl_par_en`=1) and the data bits plus the parity bit have an odd count of ones (`ctl_par_odd`=0) or an even count (`ctl_par_odd`=1). `status[3]` (framing error) is set when any stop bit samples low. Both flags are latched at completion and stay set.
- R6: A frame that completes while `status[1]` is 1 and no read is in progress sets `status[2]` (overrun). The new frame is dropped: `rx_data` keeps the old character, and a later read does not recover the dropped frame.
- R7: A `wr_stat` pulse clears `status[2]`, `status[3]` and `status[4]` on the next cycle.
- R8: While `ctl_rx_en` is 0, the receiver ignores `rxd`, raises no interrupt, and holds `status[2]`, `status[3]` and `status[4]` cleared.
- R9: While `ctl_ser_en` is 0, the receiver is idle and `status[2]` is held cleared.
- R10: `status[5]` is the OR of the overrun, framing and parity flags. `status[7:6]` and `status[0]` read 0, and every flag and `rx_data` reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling clock enable, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| ctl_ser_en | input | 1 | Serial function enable |
| ctl_rx_en | input | 1 | Receiver enable |
| ctl_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| ctl_par_en | input | 1 | Parity bit present |
| ctl_par_odd | input | 1 | 1: odd parity, 0: even parity |
| ctl_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_buf | input | 1 | Receive buffer read strobe |
| wr_stat | input | 1 | Status register write strobe |
| rx_data | output | 8 | Receive buffer contents |
| status | output | 8 | Status register |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The bench drives one bit every 32 clocks, because the tick comes every second clock. Frame completion falls about 18 clocks into the final stop bit: 2 clocks of synchroniser plus half a bit. The buffer, the flags and `rx_irq` then follow one clock later. So the bench checks a frame only after the whole final stop bit has been driven, which leaves a margin of roughly half a bit. Read and write strobes last one cycle. The flags they clear are sampled two falling edges later, and the bench counts interrupt pulses on every falling edge, so a single-cycle request cannot be missed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    localparam int CHAR_W = 8;
    localparam int STAT_W = 8;

    localparam int ST_FULL = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_FRM  = 3;
    localparam int ST_PAR  = 4;
    localparam int ST_SUM  = 5;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rxd_s,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rxd_s = s2;
    assign fall  = s3 & ~s2;
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              fall,
    input  logic              len8,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              par_err,
    output logic              frm_err
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(CHAR_W);
    localparam logic [CW-1:0] MID_START = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] MID_BIT   = CW'(OSR - 1);

    rx_state_t         state, state_nx;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [BW-1:0]     last_bit;
    logic [CHAR_W-1:0] sreg;
    logic              pacc;
    logic              ferr;
    logic              mid;

    assign last_bit = len8 ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);
    assign mid = tick && ((state == ST_START) ? (cnt == MID_START) : (cnt == MID_BIT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (fall) state_nx = ST_START;
            ST_START:  if (mid) state_nx = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (mid && bitn == last_bit) state_nx = par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (mid) state_nx = ST_STOP1;
            ST_STOP1:  if (mid) state_nx = stop2 ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (mid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (!active) state_nx = ST_IDLE;
    end

    // datapath and per-state outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sreg <= '0;
            pacc <= 1'b0;
            ferr <= 1'b0;
        end else if (!active) begin
            cnt  <= '0;
            bitn <= '0;
            sreg <= '0;
            pacc <= 1'b0;
            ferr <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (fall) begin
                        bitn <= '0;
                        sreg <= '0;
                        pacc <= 1'b0;
                        ferr <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) cnt <= mid ? '0 : cnt + 1'b1;
                end
                ST_DATA: begin
                    if (tick) cnt <= cnt + 1'b1;
                    if (mid) begin
                        sreg <= {rxd_s, sreg[CHAR_W-1:1]};
                        pacc <= pacc ^ rxd_s;
                        bitn <= bitn + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (tick) cnt <= cnt + 1'b1;
                    if (mid) pacc <= pacc ^ rxd_s;
                end
                ST_STOP1, ST_STOP2: begin
                    if (tick) cnt <= cnt + 1'b1;
                    if (mid) ferr <= ferr | ~rxd_s;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign done = active && mid &&
                  (((state == ST_STOP1) && !stop2) || (state == ST_STOP2));
    assign data    = len8 ? sreg : {1'b0, sreg[CHAR_W-1:1]};
    assign par_err = par_en & (pacc ^ par_odd);
    assign frm_err = ferr | ~rxd_s;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ser_en,
    input  logic              done,
    input  logic [CHAR_W-1:0] frame_data,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              rd_buf,
    input  logic              wr_stat,
    output logic [CHAR_W-1:0] rx_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic full, ovr, frm, par;
    logic overrun;

    assign overrun = done && full && !rd_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= done;
            if (done && !overrun) begin
                rx_data <= frame_data;
                full    <= 1'b1;
            end else if (rd_buf) begin
                full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            frm <= 1'b0;
            par <= 1'b0;
        end else if (!rx_en) begin
            ovr <= 1'b0;
            frm <= 1'b0;
            par <= 1'b0;
        end else begin
            par <= (par & ~wr_stat) | (done & par_err);
            frm <= (frm & ~wr_stat) | (done & frm_err);
            ovr <= ser_en & ((ovr & ~wr_stat) | overrun);
        end
    end

    always_comb begin
        status         = '0;
        status[ST_FULL] = full;
        status[ST_OVR]  = ovr;
        status[ST_FRM]  = frm;
        status[ST_PAR]  = par;
        status[ST_SUM]  = ovr | frm | par;
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              ctl_ser_en,
    input  logic              ctl_rx_en,
    input  logic              ctl_len8,
    input  logic              ctl_par_en,
    input  logic              ctl_par_odd,
    input  logic              ctl_stop2,
    input  logic              rd_buf,
    input  logic              wr_stat,
    output logic [CHAR_W-1:0] rx_data,
    output logic [STAT_W-1:0] status,
    output logic              rx_irq
);
    logic              rxd_s, rxd_fall;
    logic              frame_done;
    logic [CHAR_W-1:0] frame_data;
    logic              frame_par_err, frame_frm_err;
    logic              rx_active;

    assign rx_active = ctl_ser_en & ctl_rx_en;

    uart_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .rxd_s (rxd_s),
        .fall  (rxd_fall)
    );

    uart_rx_fsm #(.OSR(OSR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (rx_active),
        .tick    (os_tick),
        .rxd_s   (rxd_s),
        .fall    (rxd_fall),
        .len8    (ctl_len8),
        .par_en  (ctl_par_en),
        .par_odd (ctl_par_odd),
        .stop2   (ctl_stop2),
        .done    (frame_done),
        .data    (frame_data),
        .par_err (frame_par_err),
        .frm_err (frame_frm_err)
    );

    uart_rx_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (ctl_rx_en),
        .ser_en     (ctl_ser_en),
        .done       (frame_done),
        .frame_data (frame_data),
        .par_err    (frame_par_err),
        .frm_err    (frame_frm_err),
        .rd_buf     (rd_buf),
        .wr_stat    (wr_stat),
        .rx_data    (rx_data),
        .status     (status),
        .irq        (rx_irq)
    );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_done,
    input logic       rd_buf,
    input logic       wr_stat,
    input logic       ctl_rx_en,
    input logic       ctl_ser_en,
    input logic [4:0] st,
    input logic [7:0] rx_data,
    input logic       rx_irq
);
    // st[0] full, st[1] overrun, st[2] framing, st[3] parity, st[4] summary

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !(st[0] && !rd_buf)) |=> (st[0] && rx_irq));

    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !frame_done) |=> !st[0]);

    assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && st[0] && !rd_buf && ctl_rx_en && ctl_ser_en) |=> (st[1] && $stable(rx_data)));

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !frame_done) |=> (st[4:1] == 4'b0000));

    assert_rx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rx_en |=> ((st[4:1] == 4'b0000) && !rx_irq));

    assert_ser_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ser_en |=> !st[1]);
endmodule

bind uart_rx_core uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .rd_buf     (rd_buf),
    .wr_stat    (wr_stat),
    .ctl_rx_en  (ctl_rx_en),
    .ctl_ser_en (ctl_ser_en),
    .st         (status[5:1]),
    .rx_data    (rx_data),
    .rx_irq     (rx_irq)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
    localparam int BITC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       ser_en = 1'b1, rx_en = 1'b1, len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic       rd_buf = 1'b0, wr_stat = 1'b0;
    logic [7:0] rx_data, status;
    logic       rx_irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;
    always @(negedge clk) if (rx_irq) irq_cnt++;

    uart_rx_core dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .ctl_ser_en(ser_en), .ctl_rx_en(rx_en), .ctl_len8(len8),
        .ctl_par_en(par_en), .ctl_par_odd(par_odd), .ctl_stop2(stop2),
        .rd_buf(rd_buf), .wr_stat(wr_stat),
        .rx_data(rx_data), .status(status), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb;
        logic p;
        nb = len8 ? 8 : 7;
        p = ^(len8 ? d : {1'b0, d[6:0]}) ^ par_odd ^ bad_par;
        @(negedge clk) rxd = 1'b0;
        idle(BITC);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            idle(BITC);
        end
        if (par_en) begin
            rxd = p;
            idle(BITC);
        end
        rxd = ~bad_stop;
        idle(BITC);
        if (stop2) begin
            rxd = 1'b1;
            idle(BITC);
        end
        rxd = 1'b1;
        idle(4);
    endtask

    task automatic pulse_rd();
        rd_buf = 1'b1; idle(1); rd_buf = 1'b0; idle(1);
    endtask

    task automatic pulse_wr();
        wr_stat = 1'b1; idle(1); wr_stat = 1'b0; idle(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R10 reset status", status, 0);
        chk("R10 reset data", rx_data, 0);
        chk("R10 reset irq", rx_irq, 0);

        // near-exhaustive format / data sweep
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 32; k++) begin
                logic [7:0] d, ed;
                bit bp, bs, pe_exp;
                int irq0;
                d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 53 + f * 17 + 1) & 255);
                len8 = f[0]; par_en = f[1]; stop2 = f[2]; par_odd = k[0];
                bp = (k % 5 == 3); bs = (k % 7 == 4);
                ed = len8 ? d : {1'b0, d[6:0]};
                pe_exp = bp && par_en;
                irq0 = irq_cnt;
                send(d, bp, bs);
                chk("R2 data", rx_data, ed);
                chk("R3 full", status[1], 1);
                chk("R3 irq once", irq_cnt - irq0, 1);
                chk("R5 parity flag", status[4], pe_exp);
                chk("R5 framing flag", status[3], bs);
                chk("R10 summary", status[5], pe_exp | bs);
                chk("R10 spare bits", {status[7:6], status[0]}, 0);
                pulse_rd();
                chk("R4 read clears full", status[1], 0);
                if (pe_exp | bs) begin
                    pulse_wr();
                    chk("R7 write clears errors", status[5:2], 0);
                end
            end
        end

        len8 = 1; par_en = 0; stop2 = 0; par_odd = 0;

        // R1 glitch rejected
        begin
            int irq0;
            irq0 = irq_cnt;
            rxd = 1'b0; idle(4); rxd = 1'b1;
            idle(12 * BITC);
            chk("R1 glitch no irq", irq_cnt - irq0, 0);
            chk("R1 glitch no full", status[1], 0);
        end

        // R6 overrun
        send(8'hA5, 0, 0);
        send(8'h3C, 0, 0);
        chk("R6 overrun flag", status[2], 1);
        chk("R6 old data kept", rx_data, 8'hA5);
        chk("R6 still full", status[1], 1);
        chk("R10 summary on overrun", status[5], 1);
        pulse_rd();
        idle(40);
        chk("R6 lost frame not moved", status[1], 0);
        chk("R6 data after read", rx_data, 8'hA5);
        pulse_wr();
        chk("R7 overrun cleared", status[2], 0);

        // R9 serial enable clears overrun
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        chk("R9 overrun set", status[2], 1);
        ser_en = 1'b0; idle(2);
        chk("R9 serial off clears overrun", status[2], 0);
        ser_en = 1'b1; idle(2);
        pulse_rd();

        // R8 receive enable clears errors and ignores line
        par_en = 1'b1;
        send(8'h5A, 1, 1);
        chk("R8 errors present", status[4:3], 2'b11);
        pulse_rd();
        rx_en = 1'b0; idle(2);
        chk("R8 rx off clears errors", status[5:2], 0);
        begin
            int irq0;
            irq0 = irq_cnt;
            send(8'h0F, 1, 1);
            chk("R8 no irq while off", irq_cnt - irq0, 0);
            chk("R8 no full while off", status[1], 0);
            chk("R8 no flags while off", status[5:2], 0);
        end
        rx_en = 1'b1; idle(4);
        send(8'h96, 0, 0);
        chk("R8 receives after re-enable", rx_data, 8'h96);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule